// File: doc/BRIEF.md
# Pipeline Operand Forwarding Selector

This block decides, for each of the two ALU operands of the instruction now in the execute stage, where that operand's value should come from. There are three choices. The operand can come from the value read out of the register file. It can come from the result held in the memory stage, which belongs to the instruction one position ahead. It can come from the result held in the write-back stage, which belongs to the instruction two positions ahead. The block is purely combinational. Its inputs are the two source register numbers of the execute-stage instruction, and the destination register number and register-write flag of the memory-stage and write-back-stage instructions. Its outputs are two 2-bit selects, which drive the operand multiplexers placed in front of the ALU.

A stage can forward only when it is actually going to write a register, and only when that register is not the hard-wired zero register. When both later stages hold a result for the same register, the newer result in the memory stage is used. The two operands are resolved separately, so one cycle can forward into both operands, from the same stage or from different stages.

Top module: `fwd_unit`

## Requirements
- R1: The select encoding is 2'b00 for the register-file value, 2'b10 for the memory-stage result and 2'b01 for the write-back-stage result. 2'b11 never appears. With no producer matching, both selects are 2'b00.
- R2: An operand whose source register equals the memory-stage destination selects 2'b10, provided the memory-stage write flag is high and that destination is nonzero.
- R3: An operand whose source register equals the write-back-stage destination selects 2'b01, provided the write-back-stage write flag is high, that destination is nonzero and the memory stage does not match under R2.
- R4: When the memory stage and the write-back stage both qualify for the same operand, the select is 2'b10.
- R5: A stage whose write flag is low never causes forwarding. If the memory stage is suppressed this way, a qualifying write-back stage still selects 2'b01.
- R6: A destination register of 0 never causes forwarding, even when the write flag is high and the source register is also 0.
- R7: The two selects are resolved independently. Both may be nonzero in the same cycle, with the same value or with different values.
- R8: In a program flow where a producer writes register r, the next instruction that reads r gets 2'b10, the one after it gets 2'b01, and the one three positions later gets 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register of the execute-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination register |
| wb_wr | input | 1 | Write-back-stage instruction writes a register |
| wb_dst | input | 5 | Write-back-stage destination register |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |

## Verification
The assertions check the selects combinationally at the ports. They assume the inputs are stable whenever the selects are observed, and they assume a register number carries no unknown bits. The bench meets both assumptions. It changes inputs only one time unit after a rising edge and samples on the falling edge, and it never drives X or Z. The stimulus is made of directed cases, a sweep with a pseudo-random generator over a small register range so that matches are frequent, and a behavioural three-stage pipeline model that replays a short program in which four instructions depend on one result.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int REG_W      = 5;
    localparam int NUM_STAGES = 2;  // index 0 = memory stage (newest), 1 = write-back
    localparam int NUM_OPS    = 2;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic     wr;
        reg_idx_t dst;
    } producer_t;

    // Select code for a producer at a given age; younger stages come first.
    function automatic fwd_sel_e stage_sel(input int idx);
        return (idx == 0) ? SEL_MEM : SEL_WB;
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
(
    input  reg_idx_t  src,
    input  producer_t prod,
    output logic      hit
);
    logic dst_live;

    // Register zero is hard-wired and is never a forwarding target.
    assign dst_live = prod.wr && (prod.dst != '0);
    assign hit      = dst_live && (prod.dst == src);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
(
    input  reg_idx_t  src,
    input  producer_t prods [NUM_STAGES],
    output fwd_sel_e  sel
);
    logic [NUM_STAGES-1:0] hits;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        fwd_match u_match (
            .src  (src),
            .prod (prods[s]),
            .hit  (hits[s])
        );
    end

    // Walk from oldest to newest so the newest hit is written last and wins.
    always_comb begin
        sel = SEL_RF;
        for (int s = NUM_STAGES - 1; s >= 0; s--) begin
            if (hits[s]) sel = stage_sel(s);
        end
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
(
    input  logic [REG_W-1:0] ex_src_a,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic             mem_wr,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             wb_wr,
    input  logic [REG_W-1:0] wb_dst,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b
);
    producer_t prods [NUM_STAGES];
    reg_idx_t  srcs  [NUM_OPS];
    fwd_sel_e  sels  [NUM_OPS];

    assign prods[0] = '{wr: mem_wr, dst: mem_dst};
    assign prods[1] = '{wr: wb_wr,  dst: wb_dst};
    assign srcs[0]  = ex_src_a;
    assign srcs[1]  = ex_src_b;

    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
        fwd_operand_sel u_sel (
            .src   (srcs[o]),
            .prods (prods),
            .sel   (sels[o])
        );
    end

    assign sel_a = sels[0];
    assign sel_b = sels[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk
    import fwd_pkg::*;
(
    input logic [REG_W-1:0] ex_src_a,
    input logic [REG_W-1:0] ex_src_b,
    input logic             mem_wr,
    input logic [REG_W-1:0] mem_dst,
    input logic             wb_wr,
    input logic [REG_W-1:0] wb_dst,
    input logic [1:0]       sel_a,
    input logic [1:0]       sel_b
);
    always_comb begin
        // R1: the unused code never appears
        a_r1_legal_code: assert (sel_a != 2'b11 && sel_b != 2'b11);

        // R6: a zero source can never be satisfied by forwarding
        if (ex_src_a == '0) a_r6_zero_src_a: assert (sel_a == 2'b00);
        if (ex_src_b == '0) a_r6_zero_src_b: assert (sel_b == 2'b00);

        // R5: with no writer in flight nothing is forwarded
        if (!mem_wr && !wb_wr) a_r5_no_writer: assert (sel_a == 2'b00 && sel_b == 2'b00);

        // R4: a live memory-stage match always takes the operand
        if (mem_wr && mem_dst != '0 && mem_dst == ex_src_a)
            a_r4_mem_wins_a: assert (sel_a == 2'b10);
        if (mem_wr && mem_dst != '0 && mem_dst == ex_src_b)
            a_r4_mem_wins_b: assert (sel_b == 2'b10);

        // R3: a write-back select implies a live write-back match
        if (sel_a == 2'b01) a_r3_wb_justified_a: assert (wb_wr && wb_dst == ex_src_a && wb_dst != '0);
        if (sel_b == 2'b01) a_r3_wb_justified_b: assert (wb_wr && wb_dst == ex_src_b && wb_dst != '0);

        // R2: a memory-stage select implies a live memory-stage match
        if (sel_a == 2'b10) a_r2_mem_justified_a: assert (mem_wr && mem_dst == ex_src_a);
        if (sel_b == 2'b10) a_r2_mem_justified_b: assert (mem_wr && mem_dst == ex_src_b);
    end
endmodule

bind fwd_unit fwd_unit_chk u_chk (
    .ex_src_a (ex_src_a),
    .ex_src_b (ex_src_b),
    .mem_wr   (mem_wr),
    .mem_dst  (mem_dst),
    .wb_wr    (wb_wr),
    .wb_dst   (wb_dst),
    .sel_a    (sel_a),
    .sel_b    (sel_b)
);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/100ps
module tb_fwd_unit;
    import fwd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;  // 200 MHz

    logic [4:0] ex_src_a, ex_src_b, mem_dst, wb_dst;
    logic       mem_wr, wb_wr;
    logic [1:0] sel_a, sel_b;

    fwd_unit dut (
        .ex_src_a (ex_src_a), .ex_src_b (ex_src_b),
        .mem_wr   (mem_wr),   .mem_dst  (mem_dst),
        .wb_wr    (wb_wr),    .wb_dst   (wb_dst),
        .sel_a    (sel_a),    .sel_b    (sel_b)
    );

    typedef struct {
        logic [1:0] a;
        logic [1:0] b;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // Expected select from the requirement text (R2..R6).
    function automatic logic [1:0] model(input logic [4:0] s, input logic mw, input logic [4:0] md,
                                         input logic ww, input logic [4:0] wd);
        if (mw && md != 0 && md == s) return 2'b10;
        if (ww && wd != 0 && wd == s) return 2'b01;
        return 2'b00;
    endfunction

    task automatic drive(input logic [4:0] a, input logic [4:0] b,
                         input logic mw, input logic [4:0] md,
                         input logic ww, input logic [4:0] wd,
                         input logic [1:0] ea, input logic [1:0] eb, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        ex_src_a = a; ex_src_b = b;
        mem_wr = mw; mem_dst = md; wb_wr = ww; wb_dst = wd;
        e.a = ea; e.b = eb; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares on the falling edge, away from the driving edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (sel_a !== e.a || sel_b !== e.b) begin
                errors++;
                $display("FAIL %s: sel_a=%b sel_b=%b expected %b %b", e.tag, sel_a, sel_b, e.a, e.b);
            end
        end
    end

    // Behavioural pipeline for the program replay (R8).
    typedef struct { logic [4:0] s1; logic [4:0] s2; logic wr; logic [4:0] dst; } ins_t;

    initial begin
        ins_t prog [5];
        ins_t nop;
        ins_t ex, mem, wb;
        logic [1:0] seq_a [5];
        logic [1:0] seq_b [5];
        logic [15:0] lfsr;

        ex_src_a = 0; ex_src_b = 0; mem_wr = 0; mem_dst = 0; wb_wr = 0; wb_dst = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R1: quiet state after reset
        drive(0, 0, 0, 0, 0, 0, 2'b00, 2'b00, "R1 reset idle");
        drive(3, 4, 1, 7, 1, 9, 2'b00, 2'b00, "R1 no match");
        // R2
        drive(5, 6, 1, 5, 0, 0, 2'b10, 2'b00, "R2 mem to a");
        drive(5, 6, 1, 6, 0, 0, 2'b00, 2'b10, "R2 mem to b");
        // R3
        drive(8, 9, 0, 0, 1, 9, 2'b00, 2'b01, "R3 wb to b");
        drive(8, 9, 1, 3, 1, 8, 2'b01, 2'b00, "R3 wb to a, mem other reg");
        // R4
        drive(10, 10, 1, 10, 1, 10, 2'b10, 2'b10, "R4 mem over wb");
        // R5
        drive(11, 12, 0, 11, 0, 12, 2'b00, 2'b00, "R5 both flags low");
        drive(11, 12, 0, 11, 1, 11, 2'b01, 2'b00, "R5 mem suppressed, wb used");
        // R6
        drive(0, 0, 1, 0, 1, 0, 2'b00, 2'b00, "R6 dst zero src zero");
        drive(0, 13, 1, 0, 1, 13, 2'b00, 2'b01, "R6 mem zero ignored");
        // R7
        drive(14, 15, 1, 14, 1, 15, 2'b10, 2'b01, "R7 mixed sources");
        drive(16, 16, 0, 0, 1, 16, 2'b01, 2'b01, "R7 both from wb");

        // R8: program replay; register 2 produced by the first instruction
        nop     = '{s1: 0, s2: 0, wr: 0, dst: 0};
        prog[0] = '{s1: 1,  s2: 3,  wr: 1, dst: 2};   // sub
        prog[1] = '{s1: 2,  s2: 5,  wr: 1, dst: 12};  // and
        prog[2] = '{s1: 6,  s2: 2,  wr: 1, dst: 13};  // or
        prog[3] = '{s1: 2,  s2: 2,  wr: 1, dst: 14};  // add
        prog[4] = '{s1: 2,  s2: 15, wr: 0, dst: 0};   // store
        seq_a = '{2'b00, 2'b10, 2'b00, 2'b00, 2'b00};
        seq_b = '{2'b00, 2'b00, 2'b01, 2'b00, 2'b00};
        ex = nop; mem = nop; wb = nop;
        for (int c = 0; c < 5; c++) begin
            wb = mem; mem = ex; ex = prog[c];
            drive(ex.s1, ex.s2, mem.wr, mem.dst, wb.wr, wb.dst, seq_a[c], seq_b[c], "R8 program replay");
        end

        // Sweep over a narrow register range so matches are common (R2..R7)
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [4:0] a, b, md, wd;
            logic mw, ww;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a  = {3'b0, lfsr[1:0]};
            b  = {3'b0, lfsr[3:2]};
            md = {3'b0, lfsr[5:4]};
            wd = {3'b0, lfsr[7:6]};
            mw = lfsr[8];
            ww = lfsr[9];
            drive(a, b, mw, md, ww, wd, model(a, mw, md, ww, wd), model(b, mw, md, ww, wd),
                  "R7 sweep");
        end

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule